// File: doc/BRIEF.md
# Flash Controller Reset Sequencer

After every system reset, this block brings the flash controller's configuration state back up. It reads four words from the nonvolatile configuration area, one after another. For each word it pulses the load enable of the register that takes it. The security word comes first, then the protection word, then the option word, then the status word. The status word supplies the swap, partition, RAM-ready and emulated-EEPROM-ready bits. The configuration read port has a fixed latency of `RD_LAT` cycles. Read data appears exactly `RD_LAT` cycles after a request, and the target register samples the bus in the cycle its load enable is high.

The block holds off CPU access only for the first part of the sequence. The hold is released once the security and protection words are loaded, so CPU reads can resume while the option and status words are still being fetched. The command-complete flag stays low for the whole sequence and goes high only at its end, which is what allows user commands.

A reset that lands while a flash command is running kills that command. The block reports this with a one-cycle abort pulse, and the command is not restarted afterwards. A reset that arrives part way through the sequence restarts it from the security word.

Top module: `flash_boot_seq`

## Requirements
- R1: While `sys_rst` is high, `cmd_done` is 0, `cpu_hold` is 1, `cfg_rd_req` is 0 and all four load enables are 0.
- R2: Counting the first cycle after `sys_rst` falls as cycle 0, word k is requested at cycle k*(RD_LAT+1) with `cfg_rd_addr` = k. Its load enable is high at cycle k*(RD_LAT+1)+RD_LAT. The address encoding is 0 for security, 1 for protection, 2 for option and 3 for status.
- R3: At most one load enable is high in any cycle, and each of the four fires exactly once per completed sequence, in the order security, protection, option, status.
- R4: `cpu_hold` stays 1 through the protection load cycle and is 0 from the next cycle on. With RD_LAT=4 it is 1 at cycle 9 and 0 at cycle 10.
- R5: `cmd_done` stays 0 through the status load cycle, then rises in the next cycle and stays 1 until the next reset. With RD_LAT=4 it is 0 at cycle 19 and 1 at cycle 20.
- R6: Raising `sys_rst` part way through the sequence abandons it. After release the sequence restarts from the security word with the timing of R2, and `cpu_hold` is 1 again.
- R7: If `cmd_busy` is 1 in the cycle where `sys_rst` rises, `cmd_abort` is 1 for exactly the next cycle. It does not pulse when `cmd_busy` is 0, and it does not pulse again while reset stays high.
- R8: `cfg_rd_req` is a single-cycle pulse per word. It is never high once `cmd_done` is 1, so no aborted or finished work is resumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Synchronous system reset, active high |
| cmd_busy | input | 1 | A flash command is in progress |
| cfg_rd_req | output | 1 | Configuration word read request |
| cfg_rd_addr | output | 2 | Configuration word index |
| ld_sec | output | 1 | Load enable for the security register |
| ld_prot | output | 1 | Load enable for the protection register |
| ld_opt | output | 1 | Load enable for the option register |
| ld_stat | output | 1 | Load enable for the configuration status bits |
| cpu_hold | output | 1 | CPU flash access held off |
| cmd_done | output | 1 | Command-complete flag |
| cmd_abort | output | 1 | One-cycle pulse: running command aborted by reset |

## Verification
The bench checks the hold release on the exact cycle after the protection load. A design that releases at the wrong word would let the CPU read before protection is known, or would keep it stalled through the option and status fetches. It checks that command-complete rises only after the status load, so an early flag would show up one cycle too soon. It cuts a sequence short with a second reset: a design that resumed instead of restarting would deliver protection or option loads out of order. It also checks that the abort pulse appears only when reset meets a busy command, and appears once, so a level-style or idle-time abort is caught.

// File: rtl/flash_boot_seq.sv
module flash_boot_seq #(
  parameter int RD_LAT = 4
) (
  input  logic       clk,
  input  logic       sys_rst,
  input  logic       cmd_busy,
  output logic       cfg_rd_req,
  output logic [1:0] cfg_rd_addr,
  output logic       ld_sec,
  output logic       ld_prot,
  output logic       ld_opt,
  output logic       ld_stat,
  output logic       cpu_hold,
  output logic       cmd_done,
  output logic       cmd_abort
);
  localparam int CW = $clog2(RD_LAT + 1);

  logic          run;
  logic [1:0]    widx;
  logic [CW-1:0] cnt;
  logic          rst_d;
  logic          hit;

  assign hit         = run & ~sys_rst & (cnt == CW'(RD_LAT));
  assign cfg_rd_req  = run & ~sys_rst & (cnt == '0);
  assign cfg_rd_addr = widx;
  assign ld_sec      = hit & (widx == 2'd0);
  assign ld_prot     = hit & (widx == 2'd1);
  assign ld_opt      = hit & (widx == 2'd2);
  assign ld_stat     = hit & (widx == 2'd3);

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      run      <= 1'b1;
      widx     <= 2'd0;
      cnt      <= '0;
      cpu_hold <= 1'b1;
      cmd_done <= 1'b0;
    end else if (run) begin
      if (hit) begin
        cnt  <= '0;
        widx <= widx + 2'd1;
        if (widx == 2'd1) cpu_hold <= 1'b0;
        if (widx == 2'd3) begin
          run      <= 1'b0;
          cmd_done <= 1'b1;
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    rst_d     <= sys_rst;
    cmd_abort <= sys_rst & ~rst_d & cmd_busy;
  end

  // R3
  ld_onehot_chk: assert property (@(posedge clk) disable iff (sys_rst)
    $onehot0({ld_sec, ld_prot, ld_opt, ld_stat}));

  // R4
  hold_release_chk: assert property (@(posedge clk) disable iff (sys_rst)
    $fell(cpu_hold) |-> $past(ld_prot));

  // R5
  done_rise_chk: assert property (@(posedge clk) disable iff (sys_rst)
    $rose(cmd_done) |-> $past(ld_stat));

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (sys_rst)
    cmd_done |=> cmd_done);

  // R8
  no_req_after_done_chk: assert property (@(posedge clk) disable iff (sys_rst)
    cmd_done |-> !cfg_rd_req);
endmodule

// File: tb/flash_boot_seq_bench.sv
module flash_boot_seq_bench;
  localparam int L = 4;
  localparam int STEP = L + 1;

  logic clk = 1'b0;
  logic sys_rst = 1'b1;
  logic cmd_busy = 1'b0;
  logic cfg_rd_req;
  logic [1:0] cfg_rd_addr;
  logic ld_sec, ld_prot, ld_opt, ld_stat, cpu_hold, cmd_done, cmd_abort;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int exp_q[$];
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_boot_seq #(.RD_LAT(L)) u_flash_boot_seq (
    .clk(clk), .sys_rst(sys_rst), .cmd_busy(cmd_busy),
    .cfg_rd_req(cfg_rd_req), .cfg_rd_addr(cfg_rd_addr),
    .ld_sec(ld_sec), .ld_prot(ld_prot), .ld_opt(ld_opt), .ld_stat(ld_stat),
    .cpu_hold(cpu_hold), .cmd_done(cmd_done), .cmd_abort(cmd_abort)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_loads(input int cut);
    for (int w = 0; w < 4; w++)
      if (w * STEP + L < cut) exp_q.push_back(w * 1000 + w * STEP + L);
  endtask

  // monitor: pops scoreboard items on each load enable, checks requests and reset state
  always @(negedge clk) begin
    if (sys_rst) begin
      cyc <= 0;
      chk({cfg_rd_req, ld_sec, ld_prot, ld_opt, ld_stat} == 5'b0, "R1 idle in reset",
          int'({cfg_rd_req, ld_sec, ld_prot, ld_opt, ld_stat}), 0);
    end else begin
      automatic int lds = int'(ld_sec) + int'(ld_prot) + int'(ld_opt) + int'(ld_stat);
      automatic bit er = (cyc < 4 * STEP) && (cyc % STEP == 0);
      chk(cfg_rd_req == er, "R2/R8 request timing", int'(cfg_rd_req), int'(er));
      if (er) chk(int'(cfg_rd_addr) == cyc / STEP, "R2 address", int'(cfg_rd_addr), cyc / STEP);
      if (lds > 1) chk(1'b0, "R3 multiple loads", lds, 1);
      else if (lds == 1) begin
        automatic int kind = ld_sec ? 0 : ld_prot ? 1 : ld_opt ? 2 : 3;
        automatic int got = kind * 1000 + cyc;
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected load", got, -1);
        else begin
          automatic int e = exp_q.pop_front();
          chk(got == e, "R2/R3 load kind*1000+cycle", got, e);
        end
      end
      cyc <= cyc + 1;
    end
  end

  task automatic release_rst();
    @(posedge clk); #1 sys_rst = 1'b0;
  endtask

  task automatic assert_rst(input bit busy);
    @(posedge clk); #1 sys_rst = 1'b1; cmd_busy = busy;
    @(negedge clk);
    chk(cmd_abort == 1'b0, "R7 no early abort", int'(cmd_abort), 0);
    @(negedge clk);
    chk(cmd_abort == busy, "R7 abort pulse", int'(cmd_abort), int'(busy));
    cmd_busy = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(cmd_abort == 1'b0, "R7 single pulse", int'(cmd_abort), 0);
      chk(cpu_hold == 1'b1 && cmd_done == 1'b0, "R1/R6 reset state",
          int'({cpu_hold, cmd_done}), 2);
    end
  endtask

  task automatic full_run();
    expect_loads(1000);
    release_rst();
    repeat (2 * STEP) @(negedge clk);
    chk(cpu_hold == 1'b1, "R4 hold through protection load", int'(cpu_hold), 1);
    @(negedge clk);
    chk(cpu_hold == 1'b0, "R4 hold released", int'(cpu_hold), 0);
    repeat (2 * STEP - 1) @(negedge clk);
    chk(cmd_done == 1'b0, "R5 done low through status load", int'(cmd_done), 0);
    @(negedge clk);
    chk(cmd_done == 1'b1, "R5 done set", int'(cmd_done), 1);
    repeat (8) @(negedge clk);
    chk(cmd_done == 1'b1 && cfg_rd_req == 1'b0, "R5/R8 done sticky, no requests",
        int'({cmd_done, cfg_rd_req}), 2);
    chk(exp_q.size() == 0, "R3 all loads seen", exp_q.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(cmd_done == 1'b0 && cpu_hold == 1'b1, "R1 power-up state", int'({cmd_done, cpu_hold}), 1);
    full_run();
    assert_rst(1'b1);
    full_run();
    assert_rst(1'b0);
    expect_loads(12);
    release_rst();
    repeat (11) @(posedge clk);
    #1 sys_rst = 1'b1;
    @(negedge clk);
    chk(exp_q.size() == 0, "R6 partial loads seen", exp_q.size(), 0);
    repeat (2) @(negedge clk);
    chk(cpu_hold == 1'b1, "R6 hold re-asserted", int'(cpu_hold), 1);
    full_run();
    expect_loads(3);
    release_rst();
    repeat (2) @(posedge clk);
    #1 sys_rst = 1'b1;
    repeat (3) @(negedge clk);
    full_run();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule